// File: doc/BRIEF.md
# Configuration completion receiver

This block sits behind a configuration request path and waits for the completion that answers a request already in flight. Each receive beat carries two flags (start and end of packet) and two 32-bit data words. Once a request is armed, the block watches the beats and takes the 3-bit completion status from the start beat. When the end beat arrives, it reports either success with the returned dword or device-not-found.

For read requests the returned dword is narrowed to the byte or halfword that the original access asked for, using the low address bits of that access. A write request returns only the pass/fail verdict. A poll budget bounds the wait: if the end beat has not shown up after a fixed number of polled beats, the request ends as device-not-found. Failed reads return all-ones data.

Top module: `cfg_cpl_rx`

## Requirements
- R1: After reset `busy`, `done`, `ok` and `rdata` are all zero.
- R2: `req_start` while idle arms a request and latches `req_is_read`, `req_size` and `req_addr`, and `busy` is high in the next cycle. `req_start` while busy has no effect on the running request.
- R3: A polled beat (`beat_valid` high while busy) is taken only when flag bit 0 (start) or flag bit 1 (end) is set, or when a start beat has already been taken. Before any start beat, a polled beat with neither flag leaves the status untouched.
- R4: A taken start beat sets the completion status to bits [14:12] of `beat_dw1`. When a start and end flag arrive in the same beat, that beat's status is the one used.
- R5: A taken end beat ends the request. If the completion status is zero, `ok` is 1. If it is nonzero, `ok` is 0 and a read returns 32'hFFFFFFFF.
- R6: A successful read of size 0 (byte) returns `(beat_dw0 >> 8*addr[1:0]) & 8'hFF` of the end beat.
- R7: A successful read of size 1 (halfword) returns `(beat_dw0 >> 8*(addr & 2)) & 16'hFFFF`. Size 2 or 3 returns the whole `beat_dw0`.
- R8: If the POLL_LIMIT-th polled beat of a request carries no taken end flag, the request ends with `ok` 0 and read data 32'hFFFFFFFF. An end beat on that poll still succeeds. Cycles without `beat_valid` do not count as polls.
- R9: A write request (`req_is_read` 0) always returns `rdata` of zero, and `ok` follows the completion status.
- R10: `done` is high for exactly one cycle, in the cycle after the finishing beat, and `busy` falls in that same cycle.
- R11: Beats presented while idle produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Arm a new request (accepted when idle) |
| req_is_read | input | 1 | 1 for a read request, 0 for a write request |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 dword |
| req_addr | input | 2 | Low address bits of the original access |
| beat_valid | input | 1 | A receive beat is presented (one poll) |
| beat_flags | input | 2 | Bit 0 start of packet, bit 1 end of packet |
| beat_dw0 | input | 32 | First data word of the beat |
| beat_dw1 | input | 32 | Second data word; bits [14:12] hold the completion status on a start beat |
| busy | output | 1 | A request is waiting for its completion |
| done | output | 1 | One-cycle result strobe |
| ok | output | 1 | Result is success (1) or device-not-found (0) |
| rdata | output | 32 | Aligned read data, all-ones on a failed read, zero for writes |

## Verification
Two endings can fall in the same cycle. The end beat can land exactly on the last allowed poll, where the timeout would otherwise fire. A start and an end flag can also arrive on one beat, so that status capture and the verdict share a cycle. The bench provokes both. It pads a packet so that its end beat is the POLL_LIMIT-th poll and expects success. It sends single-beat packets with zero and nonzero status and expects success and device-not-found respectively, each with the data computed from the requirements.

// File: rtl/cfg_cpl_rx.sv
module cfg_cpl_rx #(
  parameter int POLL_LIMIT = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_start,
  input  logic        req_is_read,
  input  logic [1:0]  req_size,
  input  logic [1:0]  req_addr,
  input  logic        beat_valid,
  input  logic [1:0]  beat_flags,
  input  logic [31:0] beat_dw0,
  input  logic [31:0] beat_dw1,
  output logic        busy,
  output logic        done,
  output logic        ok,
  output logic [31:0] rdata
);
  localparam int CW = $clog2(POLL_LIMIT + 1);
  localparam logic [CW-1:0] LAST_POLL = CW'(POLL_LIMIT - 1);

  logic          busy_q, in_pkt, rd_q, done_q, ok_q;
  logic [1:0]    size_q, addr_q;
  logic [2:0]    cpl_st;
  logic [CW-1:0] polls;
  logic [31:0]   rdata_q;

  wire sop  = beat_flags[0];
  wire eop  = beat_flags[1];
  wire poll = busy_q && beat_valid;
  wire take = poll && (sop || eop || in_pkt);

  wire [2:0] st_now  = sop ? beat_dw1[14:12] : cpl_st;
  wire       fin_eop = take && eop;
  wire       fin_to  = poll && !fin_eop && (polls == LAST_POLL);
  wire       good    = fin_eop && (st_now == 3'd0);

  wire unused_dw1 = ^{beat_dw1[31:15], beat_dw1[11:0]};

  wire [31:0] sh_b = beat_dw0 >> {addr_q, 3'b000};
  wire [31:0] sh_h = beat_dw0 >> {addr_q[1], 4'b0000};

  logic [31:0] aligned;
  always_comb begin
    case (size_q)
      2'd0:    aligned = {24'd0, sh_b[7:0]};
      2'd1:    aligned = {16'd0, sh_h[15:0]};
      default: aligned = beat_dw0;
    endcase
  end

  wire [31:0] result = !rd_q ? 32'd0 : (good ? aligned : 32'hFFFF_FFFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      in_pkt  <= 1'b0;
      rd_q    <= 1'b0;
      size_q  <= 2'd0;
      addr_q  <= 2'd0;
      cpl_st  <= 3'd0;
      polls   <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      rdata_q <= 32'd0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_start) begin
          busy_q <= 1'b1;
          in_pkt <= 1'b0;
          cpl_st <= 3'd0;
          polls  <= '0;
          rd_q   <= req_is_read;
          size_q <= req_size;
          addr_q <= req_addr;
        end
      end else if (poll) begin
        polls <= polls + 1'b1;
        if (take && sop) begin
          in_pkt <= 1'b1;
          cpl_st <= beat_dw1[14:12];
        end
        if (fin_eop || fin_to) begin
          busy_q  <= 1'b0;
          in_pkt  <= 1'b0;
          done_q  <= 1'b1;
          ok_q    <= good;
          rdata_q <= result;
        end
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign ok    = ok_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/cfg_cpl_rx_chk.sv
module cfg_cpl_rx_chk #(
  parameter int POLL_LIMIT = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_start,
  input logic        req_is_read,
  input logic [1:0]  req_size,
  input logic        beat_valid,
  input logic        busy,
  input logic        done,
  input logic        ok,
  input logic [31:0] rdata
);
  localparam int CW = $clog2(POLL_LIMIT + 2);

  logic [CW-1:0] seen;
  logic          rd_m;
  logic [1:0]    sz_m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= '0;
      rd_m <= 1'b0;
      sz_m <= 2'd0;
    end else if (!busy && req_start) begin
      seen <= '0;
      rd_m <= req_is_read;
      sz_m <= req_size;
    end else if (busy && beat_valid && seen != CW'(POLL_LIMIT + 1)) begin
      seen <= seen + 1'b1;
    end
  end

  assert_start_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_start) |=> busy);

  assert_poll_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (seen < CW'(POLL_LIMIT)));

  assert_fail_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ok && rd_m) |-> (rdata == 32'hFFFF_FFFF));

  assert_byte_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok && rd_m && sz_m == 2'd0) |-> (rdata[31:8] == 24'd0));

  assert_half_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok && rd_m && sz_m == 2'd1) |-> (rdata[31:16] == 16'd0));

  assert_write_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rd_m) |-> (rdata == 32'd0));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |=> !done);
endmodule

bind cfg_cpl_rx cfg_cpl_rx_chk #(.POLL_LIMIT(POLL_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_is_read(req_is_read),
  .req_size(req_size), .beat_valid(beat_valid), .busy(busy), .done(done),
  .ok(ok), .rdata(rdata)
);

// File: tb/sim_cfg_cpl_rx.sv
`timescale 1ns/1ps
module sim_cfg_cpl_rx;
  localparam int LIMIT = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0, req_is_read = 1'b0;
  logic [1:0]  req_size = 2'd0, req_addr = 2'd0;
  logic        beat_valid = 1'b0;
  logic [1:0]  beat_flags = 2'd0;
  logic [31:0] beat_dw0 = 32'd0, beat_dw1 = 32'd0;
  logic        busy, done, ok;
  logic [31:0] rdata;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cfg_cpl_rx #(.POLL_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_is_read(req_is_read),
    .req_size(req_size), .req_addr(req_addr), .beat_valid(beat_valid),
    .beat_flags(beat_flags), .beat_dw0(beat_dw0), .beat_dw1(beat_dw1),
    .busy(busy), .done(done), .ok(ok), .rdata(rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start(input logic rd, input logic [1:0] sz, input logic [1:0] ad);
    req_start = 1'b1; req_is_read = rd; req_size = sz; req_addr = ad;
    @(posedge clk); #1;
    req_start = 1'b0;
  endtask

  task automatic beat(input logic [1:0] f, input logic [31:0] d0, input logic [31:0] d1);
    beat_valid = 1'b1; beat_flags = f; beat_dw0 = d0; beat_dw1 = d1;
    @(posedge clk); #1;
    beat_valid = 1'b0; beat_flags = 2'd0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  function automatic logic [31:0] expect_rd(input logic [1:0] sz, input logic [1:0] ad,
                                            input logic [31:0] d);
    if (sz == 2'd0) return (d >> (8 * ad)) & 32'hFF;
    if (sz == 2'd1) return (d >> (8 * (ad & 2'd2))) & 32'hFFFF;
    return d;
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [3];
    pats[0] = 32'h1234_5678; pats[1] = 32'hA5C3_0FF1; pats[2] = 32'h80FE_7F01;

    idle(3);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 busy", {31'd0, busy}, 0);
    check("R1 done", {31'd0, done}, 0);
    check("R1 ok", {31'd0, ok}, 0);
    check("R1 rdata", rdata, 0);

    // R11 beats while idle
    beat(2'b11, 32'hDEAD_BEEF, 0);
    check("R11 idle done", {31'd0, done}, 0);
    check("R11 idle busy", {31'd0, busy}, 0);

    // R6 R7 sweep of sizes, addresses and data
    for (int s = 0; s < 3; s++)
      for (int a = 0; a < 4; a++)
        for (int p = 0; p < 3; p++) begin
          start(1'b1, 2'(s), 2'(a));
          check("R2 busy after start", {31'd0, busy}, 1);
          beat(2'b01, 32'h0, 32'hFFFF_8FFF);
          beat(2'b00, 32'h0, 32'h0);
          beat(2'b10, pats[p], 32'h0);
          check(s == 0 ? "R6 byte ok" : "R7 half/word ok", {31'd0, ok}, 1);
          check(s == 0 ? "R6 byte data" : "R7 half/word data", rdata,
                expect_rd(2'(s), 2'(a), pats[p]));
          check("R10 done pulse", {31'd0, done}, 1);
          check("R10 busy falls", {31'd0, busy}, 0);
          idle(1);
          check("R10 done low", {31'd0, done}, 0);
        end

    // R4 R5 status sweep, separate beats and single beat
    for (int st = 0; st < 8; st++) begin
      start(1'b1, 2'd2, 2'd0);
      beat(2'b01, 32'h0, 32'hFFFF_8FFF | (32'(st) << 12));
      beat(2'b10, 32'h0BAD_F00D, 32'h0);
      check("R5 ok vs status", {31'd0, ok}, (st == 0) ? 1 : 0);
      check("R5 data vs status", rdata, (st == 0) ? 32'h0BAD_F00D : 32'hFFFF_FFFF);
      idle(1);
      start(1'b1, 2'd0, 2'd1);
      beat(2'b11, 32'h0000_C300, 32'(st) << 12);
      check("R4 single-beat ok", {31'd0, ok}, (st == 0) ? 1 : 0);
      check("R4 single-beat data", rdata, (st == 0) ? 32'hC3 : 32'hFFFF_FFFF);
      idle(1);
    end

    // R3 flagless beats before start are not taken
    start(1'b1, 2'd2, 2'd0);
    beat(2'b00, 32'h1111_1111, 32'h0000_7000);
    beat(2'b00, 32'h2222_2222, 32'h0000_7000);
    check("R3 no result yet", {31'd0, done}, 0);
    beat(2'b01, 32'h0, 32'h0);
    beat(2'b10, 32'h3333_3333, 32'h0);
    check("R3 ok", {31'd0, ok}, 1);
    check("R3 data", rdata, 32'h3333_3333);
    idle(1);

    // R2 second start while busy is ignored
    start(1'b1, 2'd0, 2'd3);
    start(1'b0, 2'd2, 2'd0);
    beat(2'b11, 32'hAB00_0000, 32'h0);
    check("R2 first request kept", rdata, 32'hAB);
    idle(1);

    // R8 timeout, with idle gaps that do not count
    start(1'b1, 2'd2, 2'd0);
    for (int i = 0; i < LIMIT - 1; i++) begin
      beat(2'b00, 32'h0, 32'h0);
      idle(1);
    end
    check("R8 not yet timed out", {31'd0, done}, 0);
    beat(2'b00, 32'h0, 32'h0);
    check("R8 timeout done", {31'd0, done}, 1);
    check("R8 timeout ok", {31'd0, ok}, 0);
    check("R8 timeout data", rdata, 32'hFFFF_FFFF);
    idle(1);

    // R8 end beat on the last allowed poll
    start(1'b1, 2'd1, 2'd2);
    beat(2'b01, 32'h0, 32'h0);
    for (int i = 0; i < LIMIT - 2; i++) beat(2'b00, 32'h0, 32'h0);
    beat(2'b10, 32'h5A5A_0000, 32'h0);
    check("R8 last poll ok", {31'd0, ok}, 1);
    check("R8 last poll data", rdata, 32'h5A5A);
    idle(1);

    // R9 writes
    start(1'b0, 2'd2, 2'd0);
    beat(2'b01, 32'h0, 32'h0);
    beat(2'b10, 32'hFFFF_FFFF, 32'h0);
    check("R9 write ok", {31'd0, ok}, 1);
    check("R9 write data", rdata, 32'd0);
    idle(1);
    start(1'b0, 2'd2, 2'd0);
    beat(2'b11, 32'hFFFF_FFFF, 32'h0000_2000);
    check("R9 write fail ok", {31'd0, ok}, 0);
    check("R9 write fail data", rdata, 32'd0);
    idle(1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule